// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state. Once reset is released, it holds clock enable and the data mask high and issues only no-operation commands for a long settling pause. It then issues one precharge to all banks and writes the mode register. The mode word carries the burst length, wrap type, CAS latency and write mode taken from its configuration inputs. After that it issues a fixed number of auto-refresh commands, each spaced by the refresh cycle time.

When the recovery time of the last refresh has elapsed, the block raises a done flag and releases the data mask. From then on it drives only no-operation commands, so a memory controller that shares the command pins can take over. The pause length, precharge time, mode-write time, refresh cycle time and refresh count are parameters counted in clock cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and at the first cycle after its release, cke=1, dqm=1, the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111), ba=0, addr=0 and init_done=0.
- R2: For CYC_PAUSE cycles after reset release (cycles 0..CYC_PAUSE-1), only NOP is driven, with cke and dqm high.
- R3: At cycle CYC_PAUSE a single precharge-all is driven: command 0010, addr bit 10 high, all other addr bits and ba zero.
- R4: The mode register set (command 0000, ba=0) is driven exactly CYC_RP cycles after the precharge, with cke already high on the cycle before it.
- R5: During the mode register set, addr[2:0]=cfg_burst, addr[3]=cfg_wrap (1 = interleaved), addr[6:4]=cfg_cas, addr[8:7]=0, addr[9]=cfg_single_wr (1 = single-location write), and all higher addr bits are 0.
- R6: The cycle after the mode register set is a NOP, and the first auto-refresh comes CYC_MRD cycles after the mode register set.
- R7: Exactly NUM_REF auto-refresh commands (command 0001, addr 0) are driven, each CYC_RFC cycles after the previous one, with NOPs between them.
- R8: init_done rises exactly CYC_RFC cycles after the last refresh, and dqm falls in the same cycle.
- R9: Once high, init_done stays high with only NOPs driven until reset. Asserting reset at any point restarts the whole sequence.
- R10: Every cycle not named in R3 to R8 drives a NOP with addr=0 and ba=0, and cke stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst | input | 3 | Burst length code placed in the mode word |
| cfg_wrap | input | 1 | Wrap type: 0 sequential, 1 interleaved |
| cfg_cas | input | 3 | CAS latency code placed in the mode word |
| cfg_single_wr | input | 1 | Write mode: 0 burst write, 1 single-location write |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask, high until initialization completes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address, also carries the mode word |
| init_done | output | 1 | High once the device is ready; sticky until reset |

## Verification
The bench builds the block with a 5-cycle pause, CYC_RP=3, CYC_MRD=2, CYC_RFC=4 and eight refreshes, so the whole sequence takes about 42 cycles. At that length every cycle of the sequence can be compared with a schedule computed in the bench, for all 256 combinations of the four configuration inputs. The short run also makes an extra case cheap: a reset asserted in the middle of the refresh phase, followed by a full restart.

// File: rtl/sdram_init_pkg.sv
// Shared definitions for the SDRAM initialization sequencer.
// Assumes the command is presented as {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRE,
        ST_WAIT_RP,
        ST_MRS,
        ST_WAIT_MRD,
        ST_REF,
        ST_WAIT_RFC,
        ST_DONE
    } init_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counting delay timer. Starts at RST_VAL out of reset, can be
// reloaded, and stops at zero. Assumes RST_VAL fits in W bits.
module sdram_init_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count down toward zero, or reload when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_init_refcnt.sv
// Counts issued auto-refresh commands and flags when the required
// number has been reached. Assumes inc is never raised past TOTAL.
module sdram_init_refcnt #(
    parameter int unsigned TOTAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic reached
);

    localparam int unsigned RW = $clog2(TOTAL + 1);

    logic [RW-1:0] cnt;

    // Advance once per refresh command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign reached = (cnt == RW'(TOTAL));

    // R7
    refcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RW'(TOTAL));

endmodule

// File: rtl/sdram_init_mode.sv
// Builds the mode register word from the configuration inputs.
// Field positions follow what the memory decodes; assumes ADDR_W >= 11.
module sdram_init_mode #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [2:0]        burst,
    input  logic              wrap,
    input  logic [2:0]        cas,
    input  logic              single_wr,
    output logic [ADDR_W-1:0] word
);

    // Place each field at its decoded position, all else zero.
    always_comb begin
        word      = '0;
        word[2:0] = burst;
        word[3]   = wrap;
        word[6:4] = cas;
        word[9]   = single_wr;
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Power-up initialization sequencer for a synchronous DRAM.
// Order: pause with NOPs, precharge-all, mode register set, NUM_REF
// auto-refreshes, then done. All CYC_* timings are in clock cycles
// and must be at least 2 (CYC_PAUSE at least 1). The cfg_* inputs
// must be stable at the mode register set cycle.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned CYC_PAUSE = 20000,
    parameter int unsigned CYC_RP    = 3,
    parameter int unsigned CYC_MRD   = 2,
    parameter int unsigned CYC_RFC   = 7,
    parameter int unsigned NUM_REF   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst,
    input  logic              cfg_wrap,
    input  logic [2:0]        cfg_cas,
    input  logic              cfg_single_wr,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned MAX_A  = (CYC_RP > CYC_MRD) ? CYC_RP : CYC_MRD;
    localparam int unsigned MAX_B  = (MAX_A > CYC_RFC) ? MAX_A : CYC_RFC;
    localparam int unsigned MAX_C  = (MAX_B > CYC_PAUSE) ? MAX_B : CYC_PAUSE;
    localparam int unsigned TW     = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] LD_RP  = TW'(CYC_RP - 2);
    localparam logic [TW-1:0] LD_MRD = TW'(CYC_MRD - 2);
    localparam logic [TW-1:0] LD_RFC = TW'(CYC_RFC - 2);

    init_state_e   st, st_nxt;
    logic          tmr_load, tmr_zero, ref_inc, ref_reached;
    logic [TW-1:0] tmr_val;
    logic [ADDR_W-1:0] mode_word;
    sdram_cmd_e    cmd;
    logic          done_q;

    sdram_init_timer #(.W(TW), .RST_VAL(CYC_PAUSE - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    sdram_init_refcnt #(.TOTAL(NUM_REF)) u_refcnt (
        .clk(clk), .rst_n(rst_n), .inc(ref_inc), .reached(ref_reached)
    );

    sdram_init_mode #(.ADDR_W(ADDR_W)) u_mode (
        .burst(cfg_burst), .wrap(cfg_wrap), .cas(cfg_cas),
        .single_wr(cfg_single_wr), .word(mode_word)
    );

    // Select the next step and the timer reload for each wait.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_inc  = 1'b0;
        unique case (st)
            ST_PAUSE:    if (tmr_zero) st_nxt = ST_PRE;
            ST_PRE:      begin st_nxt = ST_WAIT_RP;  tmr_load = 1'b1; tmr_val = LD_RP;  end
            ST_WAIT_RP:  if (tmr_zero) st_nxt = ST_MRS;
            ST_MRS:      begin st_nxt = ST_WAIT_MRD; tmr_load = 1'b1; tmr_val = LD_MRD; end
            ST_WAIT_MRD: if (tmr_zero) st_nxt = ST_REF;
            ST_REF: begin
                st_nxt   = ST_WAIT_RFC;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
                ref_inc  = 1'b1;
            end
            ST_WAIT_RFC: if (tmr_zero) st_nxt = ref_reached ? ST_DONE : ST_REF;
            ST_DONE:     st_nxt = ST_DONE;
            default:     st_nxt = ST_PAUSE;
        endcase
    end

    // Hold the current step; reset restarts from the pause.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_PAUSE;
        else        st <= st_nxt;
    end

    // Ready flag, set on entry to the final step and kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_q <= 1'b0;
        else if (st_nxt == ST_DONE)    done_q <= 1'b1;
    end

    // Decode the command and address for the current step.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (st)
            ST_PRE: begin cmd = CMD_PRE; addr[10] = 1'b1; end
            ST_MRS: begin cmd = CMD_MRS; addr = mode_word; end
            ST_REF: cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba        = '0;
    assign cke       = 1'b1;
    assign dqm       = (st != ST_DONE);
    assign init_done = done_q;

    // R8
    dqm_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> dqm);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9
    done_only_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    // R6
    nop_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MRS) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    // R4
    cke_before_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_MRS) |-> ($past(cke) && cke));

endmodule

// File: tb/sdram_init_seq_test.sv
// Sweeps all configuration inputs and checks every cycle of the
// sequence against a schedule computed from the requirements.
module sdram_init_seq_test;

    localparam int AW = 12;
    localparam int BW = 2;
    localparam int P   = 5;
    localparam int RP  = 3;
    localparam int MRD = 2;
    localparam int RFC = 4;
    localparam int NR  = 8;
    localparam int T_PRE  = P;
    localparam int T_MRS  = P + RP;
    localparam int T_REF0 = T_MRS + MRD;
    localparam int T_DONE = T_REF0 + NR * RFC;
    localparam int VW = 1 + 1 + 4 + BW + AW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_burst = '0;
    logic cfg_wrap = 1'b0;
    logic [2:0] cfg_cas = '0;
    logic cfg_single_wr = 1'b0;
    logic cke, dqm, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(AW), .BA_W(BW), .CYC_PAUSE(P), .CYC_RP(RP),
        .CYC_MRD(MRD), .CYC_RFC(RFC), .NUM_REF(NR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_wrap(cfg_wrap),
        .cfg_cas(cfg_cas), .cfg_single_wr(cfg_single_wr), .cke(cke), .dqm(dqm),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
        .addr(addr), .init_done(init_done)
    );

    function automatic logic [VW-1:0] observed();
        return {cke, dqm, cs_n, ras_n, cas_n, we_n, ba, addr, init_done};
    endfunction

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Expected pin vector for cycle n after reset release.
    function automatic logic [VW-1:0] expect_at(input int n);
        logic [3:0] c = 4'b0111;
        logic [AW-1:0] a = '0;
        logic done = (n >= T_DONE);
        if (n == T_PRE) begin
            c = 4'b0010; a[10] = 1'b1;
        end else if (n == T_MRS) begin
            c = 4'b0000;
            a = AW'(cfg_burst) | (AW'(cfg_wrap) << 3) | (AW'(cfg_cas) << 4)
              | (AW'(cfg_single_wr) << 9);
        end else if (n >= T_REF0 && n < T_DONE && ((n - T_REF0) % RFC) == 0) begin
            c = 4'b0001;
        end
        return {1'b1, ~done, c, {BW{1'b0}}, a, done};
    endfunction

    function automatic string tag_at(input int n);
        if (n < T_PRE)  return "R2";
        if (n == T_PRE) return "R3";
        if (n == T_MRS) return "R4";
        if (n == T_MRS + 1) return "R6";
        if (n >= T_REF0 && n < T_DONE && ((n - T_REF0) % RFC) == 0) return "R7";
        if (n == T_DONE) return "R8";
        if (n > T_DONE) return "R9";
        return "R10";
    endfunction

    // Reset for two cycles, checking the reset state (R1).
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1", observed(), {1'b1, 1'b1, 4'b0111, {BW{1'b0}}, {AW{1'b0}}, 1'b0});
        end
    endtask

    // Release reset and check cycles 0..last against the schedule.
    task automatic run_seq(input int last);
        rst_n = 1'b1;
        for (int n = 0; n <= last; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            chk(tag_at(n), observed(), expect_at(n));
            if (n == T_MRS)
                chk("R5", {{(VW-AW){1'b0}}, addr}, {{(VW-AW){1'b0}}, expect_at(n)[AW:1]});
            if (n == 0)
                chk("R1", observed(), {1'b1, 1'b1, 4'b0111, {BW{1'b0}}, {AW{1'b0}}, 1'b0});
        end
    endtask

    initial begin
        for (int cfg = 0; cfg < 256; cfg++) begin
            {cfg_single_wr, cfg_cas, cfg_wrap, cfg_burst} = 8'(cfg);
            apply_reset();
            run_seq(T_DONE + 6);
        end
        // R9: reset in the middle of the refresh phase restarts everything.
        {cfg_single_wr, cfg_cas, cfg_wrap, cfg_burst} = 8'hA5;
        apply_reset();
        run_seq(T_REF0 + RFC + 1);
        apply_reset();
        run_seq(T_DONE + 10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule